// File: doc/BRIEF.md
# First-Arrival Two-Source Merge

This block joins two upstream request/acknowledge channels, each carrying a data word, into one downstream channel of the same kind. Items from both sources leave on the single output one at a time. The source that raised its request earlier is forwarded first. The other source waits with its request held high, and nothing else is stored for it.

A source raises its request and holds its data steady until it receives its own acknowledge pulse. It then drops the request for at least one cycle before it offers a new item. Downstream sees one request at a time. It answers with a one-cycle acknowledge pulse. The block then releases only the source whose item was taken and drops the downstream request for at least one cycle before it forwards the next item.

Top module: `fam_merge2`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `m_req`, `s0_ack` and `s1_ack` are low.
- R2: When a source raises its request and the block is idle, `m_req` is high in the next cycle, and `m_data` carries that source's data.
- R3: If one source raised its request in an earlier cycle than the other, that source's item is forwarded first. The other item follows once the first has been acknowledged.
- R4: If both requests rise in the same cycle, source 0 (`s0_*`) is forwarded first.
- R5: In the cycle after `m_req` and `m_ack` are both high, `m_req` is low. A pending item from the other source is presented in the cycle after that.
- R6: In the cycle after a downstream acknowledge, the acknowledge of the source that was forwarded is high for exactly one cycle. The two source acknowledges are never high together, and neither is high at any other time.
- R7: A source that drops its request before it is granted is removed from the arrival record. It is never forwarded and never acknowledged.
- R8: While `m_req` is high and has not been acknowledged, the grant does not change: `m_data` stays the data of the granted source, even if the other source arrives.
- R9: `m_ack` has no effect while `m_req` is low: no source acknowledge follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s0_req | input | 1 | Source 0 request, held until its acknowledge |
| s0_data | input | DATA_W | Source 0 data, stable while requesting |
| s0_ack | output | 1 | Source 0 acknowledge pulse |
| s1_req | input | 1 | Source 1 request, held until its acknowledge |
| s1_data | input | DATA_W | Source 1 data, stable while requesting |
| s1_ack | output | 1 | Source 1 acknowledge pulse |
| m_req | output | 1 | Merged request toward downstream |
| m_data | output | DATA_W | Data of the granted source |
| m_ack | input | 1 | Downstream acknowledge pulse |

## Verification
The assertions check the handshake rules on every cycle. Source acknowledges are single pulses that never overlap and only follow a taken downstream transfer. The downstream request returns to zero after each acknowledge, and the output data is frozen while a transfer is open. Which source is served first cannot be seen in one cycle. The bench scenarios therefore cover it: staggered arrivals, same-cycle ties, withdrawals before grant, and random traffic. The bench compares each forwarded word against an arrival queue it keeps on its own.

// File: rtl/fam_pkg.sv
`timescale 1ns/1ps
package fam_pkg;
    localparam int NSRC = 2;

    typedef struct packed {
        logic            busy;   // downstream transfer open
        logic            gnt;    // granted source index
        logic [NSRC-1:0] pend;   // sources waiting in arrival record
        logic            older;  // earliest pending source
        logic [NSRC-1:0] ack;    // source acknowledge pulses
    } ord_state_t;
endpackage

// File: rtl/fam_edge.sv
`timescale 1ns/1ps
module fam_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_rise
        assign rise[i] = lvl[i] & ~prev_q[i];
    end
endmodule

// File: rtl/fam_mux.sv
`timescale 1ns/1ps
module fam_mux #(
    parameter int W = 16,
    parameter int N = 2,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [SW-1:0]  sel,
    input  logic [N*W-1:0] din,
    output logic [W-1:0]   dout
);
    always_comb begin
        dout = din[sel*W +: W];
    end
endmodule

// File: rtl/fam_order.sv
`timescale 1ns/1ps
module fam_order
    import fam_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] rise,
    input  logic            dn_ack,
    output logic            busy,
    output logic            gnt,
    output logic [NSRC-1:0] src_ack
);
    ord_state_t st_d, st_q;
    logic [NSRC-1:0] live, cand;
    logic            first;

    always_comb begin
        st_d    = st_q;
        st_d.ack = '0;
        live    = st_q.pend & req;      // withdrawn requests fall out here
        cand    = live | rise;

        // earliest candidate: recorded order, then waiting over new, tie to 0
        if (live == 2'b11)  first = st_q.older;
        else if (live[0])   first = 1'b0;
        else if (live[1])   first = 1'b1;
        else if (rise[0])   first = 1'b0;
        else                first = 1'b1;

        if (st_q.busy) begin
            st_d.pend  = cand;
            st_d.older = first;
            if (dn_ack) begin
                st_d.busy           = 1'b0;
                st_d.ack[st_q.gnt]  = 1'b1;
            end
        end else begin
            st_d.older = first;
            if (|cand) begin
                st_d.busy = 1'b1;
                st_d.gnt  = first;
                st_d.pend = cand & ~(2'b01 << first);
            end else begin
                st_d.pend = cand;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign gnt     = st_q.gnt;
    assign src_ack = st_q.ack;
endmodule

// File: rtl/fam_merge2.sv
`timescale 1ns/1ps
module fam_merge2
    import fam_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s0_req,
    input  logic [DATA_W-1:0] s0_data,
    output logic              s0_ack,
    input  logic              s1_req,
    input  logic [DATA_W-1:0] s1_data,
    output logic              s1_ack,
    output logic              m_req,
    output logic [DATA_W-1:0] m_data,
    input  logic              m_ack
);
    logic [NSRC-1:0] req_v, rise_v, ack_v;
    logic            gnt;

    assign req_v = {s1_req, s0_req};

    fam_edge #(.N(NSRC)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (req_v),
        .rise (rise_v)
    );

    fam_order u_order (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req_v),
        .rise   (rise_v),
        .dn_ack (m_ack),
        .busy   (m_req),
        .gnt    (gnt),
        .src_ack(ack_v)
    );

    fam_mux #(.W(DATA_W), .N(NSRC)) u_mux (
        .sel (gnt),
        .din ({s1_data, s0_data}),
        .dout(m_data)
    );

    assign s0_ack = ack_v[0];
    assign s1_ack = ack_v[1];
endmodule

// File: rtl/fam_merge2_chk.sv
`timescale 1ns/1ps
module fam_merge2_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s0_req,
    input logic [DATA_W-1:0] s0_data,
    input logic              s0_ack,
    input logic              s1_req,
    input logic [DATA_W-1:0] s1_data,
    input logic              s1_ack,
    input logic              m_req,
    input logic [DATA_W-1:0] m_data,
    input logic              m_ack
);
    assert_ack_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({s1_ack, s0_ack}));

    assert_ack0_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s0_ack |=> !s0_ack);

    assert_ack1_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s1_ack |=> !s1_ack);

    assert_ack_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_ack || s1_ack) |-> $past(m_req && m_ack));

    assert_return_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_ack) |=> !m_req);

    assert_grant_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && $past(m_req) && !$past(m_ack)) |-> $stable(m_data));

    assert_req_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_req) |-> $past(s0_req || s1_req));

    assert_idle_ack_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !m_req |=> !(s0_ack || s1_ack));
endmodule

bind fam_merge2 fam_merge2_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_fam_merge2.sv
`timescale 1ns/1ps
module tb_fam_merge2;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic b_req [2];
    logic [W-1:0] b_dat [2];
    logic s0_ack, s1_ack, m_req, m_ack;
    logic [W-1:0] m_data;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fam_merge2 #(.DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n),
        .s0_req(b_req[0]), .s0_data(b_dat[0]), .s0_ack(s0_ack),
        .s1_req(b_req[1]), .s1_data(b_dat[1]), .s1_ack(s1_ack),
        .m_req(m_req), .m_data(m_data), .m_ack(m_ack)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic src_ack(input int s);
        return (s == 0) ? s0_ack : s1_ack;
    endfunction

    // downstream takes the item; the source of index src must be released
    task automatic finish_xfer(input int src, input string tag);
        m_ack = 1'b1;
        tick();
        m_ack = 1'b0;
        check(src_ack(src) == 1'b1, {tag, " R6 own ack"}, src_ack(src), 1);
        check(src_ack(1 - src) == 1'b0, {tag, " R6 other ack"}, src_ack(1 - src), 0);
        check(m_req == 1'b0, {tag, " R5 return to zero"}, m_req, 0);
        b_req[src] = 1'b0;
        tick();
        check({s1_ack, s0_ack} == 2'b00, {tag, " R6 single pulse"}, {s1_ack, s0_ack}, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int q[$];
        bit act [2];
        bit prev_mreq;
        logic [W-1:0] prev_data;
        int ack_wait;
        void'($urandom(32'd4242));
        b_req[0] = 0; b_req[1] = 0; b_dat[0] = '0; b_dat[1] = '0; m_ack = 0;
        repeat (3) tick();
        check({m_req, s1_ack, s0_ack} == 3'b000, "R1 reset outputs", {m_req, s1_ack, s0_ack}, 0);
        rst_n = 1'b1;
        tick();
        check({m_req, s1_ack, s0_ack} == 3'b000, "R1 after reset", {m_req, s1_ack, s0_ack}, 0);

        // R2: single request from source 1
        b_dat[1] = 16'h1111; b_req[1] = 1'b1;
        tick();
        check(m_req == 1'b1, "R2 request forwarded", m_req, 1);
        check(m_data == 16'h1111, "R2 data of source", m_data, 16'h1111);
        finish_xfer(1, "R2");

        // R4: same-cycle tie, source 0 first; R5 then the other follows
        b_dat[0] = 16'hA0A0; b_dat[1] = 16'hB1B1;
        b_req[0] = 1'b1; b_req[1] = 1'b1;
        tick();
        check(m_data == 16'hA0A0, "R4 tie goes to source 0", m_data, 16'hA0A0);
        finish_xfer(0, "R4");
        check(m_req == 1'b1, "R5 pending follows", m_req, 1);
        check(m_data == 16'hB1B1, "R5 pending data", m_data, 16'hB1B1);
        finish_xfer(1, "R5");

        // R3 / R8: source 1 earlier, source 0 later does not preempt
        b_dat[0] = 16'h0C0C; b_dat[1] = 16'h1D1D;
        b_req[1] = 1'b1;
        tick();
        b_req[0] = 1'b1;
        tick();
        check(m_data == 16'h1D1D, "R3 earlier source first", m_data, 16'h1D1D);
        repeat (3) tick();
        check(m_req == 1'b1 && m_data == 16'h1D1D, "R8 grant held", m_data, 16'h1D1D);
        finish_xfer(1, "R3");
        check(m_data == 16'h0C0C && m_req, "R3 later source second", m_data, 16'h0C0C);
        finish_xfer(0, "R3b");

        // R7: source 1 withdraws while waiting
        b_dat[0] = 16'h7070; b_dat[1] = 16'h7171;
        b_req[0] = 1'b1;
        tick();
        b_req[1] = 1'b1;
        tick();
        b_req[1] = 1'b0;
        tick();
        finish_xfer(0, "R7");
        for (int k = 0; k < 4; k++) begin
            check(m_req == 1'b0 && s1_ack == 1'b0, "R7 withdrawn not forwarded",
                  {s1_ack, m_req}, 0);
            tick();
        end

        // R9: downstream ack while idle
        m_ack = 1'b1;
        tick();
        m_ack = 1'b0;
        check({s1_ack, s0_ack} == 2'b00, "R9 idle ack ignored", {s1_ack, s0_ack}, 0);
        tick();
        check(m_req == 1'b0, "R9 idle stays idle", m_req, 0);

        // random traffic against a bench-side arrival queue
        act[0] = 0; act[1] = 0; prev_mreq = 0; prev_data = '0; ack_wait = -1;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            bit dropped [2];
            dropped[0] = 0; dropped[1] = 0;
            m_ack = 1'b0;
            if (ack_wait >= 0) begin
                check(src_ack(ack_wait) == 1'b1, "R6 random own ack", src_ack(ack_wait), 1);
                check(src_ack(1 - ack_wait) == 1'b0, "R6 random other ack",
                      src_ack(1 - ack_wait), 0);
                check(m_req == 1'b0, "R5 random return to zero", m_req, 0);
                b_req[ack_wait] = 1'b0;
                act[ack_wait] = 0;
                dropped[ack_wait] = 1;
                ack_wait = -1;
            end else begin
                check({s1_ack, s0_ack} == 2'b00, "R6 random no stray ack", {s1_ack, s0_ack}, 0);
            end
            if (m_req) begin
                if (!prev_mreq) begin
                    check(q.size() > 0, "R3 random forward has arrival", q.size(), 1);
                    if (q.size() > 0)
                        check(m_data == b_dat[q[0]], "R3 random arrival order",
                              m_data, b_dat[q[0]]);
                end else begin
                    check(m_data == prev_data, "R8 random grant held", m_data, prev_data);
                end
                if ($urandom % 3 == 0 && q.size() > 0) begin
                    m_ack = 1'b1;
                    ack_wait = q.pop_front();
                end
            end else if ($urandom % 8 == 0) begin
                m_ack = 1'b1;   // R9: ignored while idle
            end
            prev_mreq = m_req;
            prev_data = m_data;
            for (int i = 0; i < 2; i++) begin
                if (!act[i] && !dropped[i] && ($urandom % 4 == 0)) begin
                    act[i] = 1;
                    b_dat[i] = W'($urandom);
                    b_req[i] = 1'b1;
                    q.push_back(i);
                end
            end
            tick();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule